// File: doc/BRIEF.md
# Integer ALU with NZCV flags

This block is a 32-bit integer arithmetic unit with its own four-bit condition register. On each cycle the caller presents an operation code and two operands that are already zero-extended. The result appears in the same cycle, without a clock edge. A result-write strobe and a flag-write strobe, both decoded from the operation, tell the caller what to commit. The carry input of the carry-using operations is the C bit held in the block's own flag register.

The flag register holds negative, zero, carry and overflow. It changes on a rising clock edge, and only when the current operation calls for a flag update. Subtraction is done as A plus the inverted B plus one. Carry therefore means "no borrow", and subtract-with-carry takes away the inverse of C. The three compare-style operations update the flags and drop the write strobe for the result. The logical test and the multiply update only N and Z.

Top module: `alu_nzcv`

## Requirements
- R1: Operation code 0 (add) and code 6 (compare-negative) form A + B. C is the carry out of bit 31, so 0x80000000 + 0x80000000 gives result 0 with C set.
- R2: Operation code 1 (add-with-carry) forms A + B + C, where C is the registered carry flag.
- R3: Operation code 2 (subtract) and code 5 (compare) form A - B with C set when A >= B unsigned (no borrow), so 0x10 - 0x01 sets C. Code 3 (subtract-with-carry) forms A - B - (1 - C).
- R4: Operation code 4 (negate) forms 0 - B. C is set only when B is zero and V only when B is 0x80000000.
- R5: V is set when an add-type or subtract-type result has a sign that its operands cannot produce. 0x7FFFFFFF + 1 sets V and N and leaves C clear.
- R6: flags_o is {N, Z, C, V} with N at bit 3 and V at bit 0. N is result bit 31 and Z is set when the result is zero. The register loads only on a clock edge where flag_we_o is high, and otherwise holds its value.
- R7: Codes 5, 6 and 7 (compare, compare-negative, test) drive res_we_o low and flag_we_o high. Codes 0 to 4 and 8 drive both strobes high.
- R8: Operation code 7 (test) forms A & B and updates only N and Z. C and V keep their previous values.
- R9: Operation code 8 (multiply) returns the low 32 bits of A * B, the same word for signed and unsigned operands. It updates N and Z and keeps C and V.
- R10: A synchronous active-high reset clears all four flags to zero on the next rising edge.
- R11: Operation codes 9 to 15 are reserved. They give result 0 with both strobes low, and they leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Combinational result |
| res_we_o | output | 1 | Result should be written |
| flag_we_o | output | 1 | Flags update on the next edge |
| flags_o | output | 4 | Registered {N, Z, C, V} |

## Verification
Directed cases target the sign and carry boundaries:
- equal sign bits set that produce a carry without overflow, and the reverse;
- subtractions on both sides of A = B;
- negation of zero and of the most negative value;
- carry-using operations entered with C both set and clear.

Test and multiply follow operations that leave C and V set, so that preserving a flag can be told apart from clearing it. Random operands, drawn partly from a pool of boundary words, sweep all sixteen operation codes. A bench model predicts each result, strobe and flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_NEG = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_MUL = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        RES_SUM  = 2'd0,
        RES_AND  = 2'd1,
        RES_MUL  = 2'd2,
        RES_NONE = 2'd3
    } res_sel_e;

    typedef struct packed {
        logic     n;
        logic     z;
        logic     c;
        logic     v;
    } nzcv_t;

    typedef struct packed {
        logic     zero_a;
        logic     inv_b;
        cin_sel_e cin;
        res_sel_e rsel;
        logic     res_we;
        logic     upd_nz;
        logic     upd_cv;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output alu_ctrl_t       ctrl_o
);
    always_comb begin
        ctrl_o = '{zero_a: 1'b0, inv_b: 1'b0, cin: CIN_ZERO, rsel: RES_NONE,
                   res_we: 1'b0, upd_nz: 1'b0, upd_cv: 1'b0};
        unique case (op_i)
            OP_ADD, OP_CMN: begin
                ctrl_o.rsel   = RES_SUM;
                ctrl_o.res_we = (op_i == OP_ADD);
                ctrl_o.upd_nz = 1'b1;
                ctrl_o.upd_cv = 1'b1;
            end
            OP_ADC: begin
                ctrl_o.cin    = CIN_FLAG;
                ctrl_o.rsel   = RES_SUM;
                ctrl_o.res_we = 1'b1;
                ctrl_o.upd_nz = 1'b1;
                ctrl_o.upd_cv = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                ctrl_o.inv_b  = 1'b1;
                ctrl_o.cin    = CIN_ONE;
                ctrl_o.rsel   = RES_SUM;
                ctrl_o.res_we = (op_i == OP_SUB);
                ctrl_o.upd_nz = 1'b1;
                ctrl_o.upd_cv = 1'b1;
            end
            OP_SBC: begin
                ctrl_o.inv_b  = 1'b1;
                ctrl_o.cin    = CIN_FLAG;
                ctrl_o.rsel   = RES_SUM;
                ctrl_o.res_we = 1'b1;
                ctrl_o.upd_nz = 1'b1;
                ctrl_o.upd_cv = 1'b1;
            end
            OP_NEG: begin
                ctrl_o.zero_a = 1'b1;
                ctrl_o.inv_b  = 1'b1;
                ctrl_o.cin    = CIN_ONE;
                ctrl_o.rsel   = RES_SUM;
                ctrl_o.res_we = 1'b1;
                ctrl_o.upd_nz = 1'b1;
                ctrl_o.upd_cv = 1'b1;
            end
            OP_TST: begin
                ctrl_o.rsel   = RES_AND;
                ctrl_o.upd_nz = 1'b1;
            end
            OP_MUL: begin
                ctrl_o.rsel   = RES_MUL;
                ctrl_o.res_we = 1'b1;
                ctrl_o.upd_nz = 1'b1;
            end
            default: begin
                ctrl_o.rsel   = RES_NONE;
            end
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         zero_a_i,
    input  logic         inv_b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W:0]   full;

    always_comb begin
        x      = zero_a_i ? '0 : a_i;
        y      = inv_b_i ? ~b_i : b_i;
        full   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        // Overflow: like-signed inputs give an unlike-signed sum
        ovf_o  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    // Low word only; identical for signed and unsigned operands
    always_comb prod_o = a_i * b_i;
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd_nz_i,
    input  logic  upd_cv_i,
    input  nzcv_t next_i,
    output nzcv_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            if (upd_nz_i) begin
                flags_o.n <= next_i.n;
                flags_o.z <= next_i.z;
            end
            if (upd_cv_i) begin
                flags_o.c <= next_i.c;
                flags_o.v <= next_i.v;
            end
        end
    end
endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [W-1:0]      result_o,
    output logic              res_we_o,
    output logic              flag_we_o,
    output logic [FLAG_W-1:0] flags_o
);
    alu_ctrl_t    ctrl;
    nzcv_t        flags_q;
    nzcv_t        flags_d;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;
    logic         ovf;
    logic [W-1:0] prod;

    alu_decode u_dec (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    always_comb begin
        unique case (ctrl.cin)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = flags_q.c;
            default:  cin = 1'b0;
        endcase
    end

    alu_addsub #(.W(W)) u_add (
        .a_i      (a_i),
        .b_i      (b_i),
        .zero_a_i (ctrl.zero_a),
        .inv_b_i  (ctrl.inv_b),
        .cin_i    (cin),
        .sum_o    (sum),
        .cout_o   (cout),
        .ovf_o    (ovf)
    );

    alu_mul #(.W(W)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    always_comb begin
        unique case (ctrl.rsel)
            RES_SUM: result_o = sum;
            RES_AND: result_o = a_i & b_i;
            RES_MUL: result_o = prod;
            default: result_o = '0;
        endcase
        flags_d.n = result_o[W-1];
        flags_d.z = (result_o == '0);
        flags_d.c = cout;
        flags_d.v = ovf;
        res_we_o  = ctrl.res_we;
        flag_we_o = ctrl.upd_nz | ctrl.upd_cv;
    end

    alu_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .upd_nz_i (ctrl.upd_nz),
        .upd_cv_i (ctrl.upd_cv),
        .next_i   (flags_d),
        .flags_o  (flags_q)
    );

    assign flags_o = flags_q;
endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [W-1:0]      a_i,
    input logic [W-1:0]      b_i,
    input logic [W-1:0]      result_o,
    input logic              res_we_o,
    input logic              flag_we_o,
    input logic [FLAG_W-1:0] flags_o
);
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we_o |=> $stable(flags_o)); // R6

    AST_NZ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |=> (flags_o[3] == $past(result_o[W-1])) &&
                      (flags_o[2] == ($past(result_o) == '0))); // R6

    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD && a_i[W-1] && b_i[W-1]) |=> flags_o[1]); // R1

    AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB) |=> (flags_o[1] == ($past(a_i) >= $past(b_i)))); // R3

    AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP || op_i == OP_CMN || op_i == OP_TST) |-> (!res_we_o && flag_we_o)); // R7

    AST_TST_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_TST) |=> (flags_o[1:0] == $past(flags_o[1:0]))); // R8

    AST_MUL_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MUL) |=> (flags_o[1:0] == $past(flags_o[1:0]))); // R9

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd8) |-> (!res_we_o && !flag_we_o && result_o == '0)); // R11
endmodule

bind alu_nzcv alu_nzcv_chk #(.W(W)) u_chk (.*);

// File: tb/alu_nzcv_test.sv
module alu_nzcv_test;
    import alu_pkg::*;

    localparam int W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OP_W-1:0]   op_i = '0;
    logic [W-1:0]      a_i = '0;
    logic [W-1:0]      b_i = '0;
    logic [W-1:0]      result_o;
    logic              res_we_o;
    logic              flag_we_o;
    logic [FLAG_W-1:0] flags_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] mflags = 4'h0;

    alu_nzcv #(.W(W)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd6: return "R1";
            4'd1:       return "R2";
            4'd2, 4'd3, 4'd5: return "R3";
            4'd4:       return "R4";
            4'd7:       return "R8";
            4'd8:       return "R9";
            default:    return "R11";
        endcase
    endfunction

    // Bench reference model built from the requirements
    task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] r, output logic rwe, output logic fwe,
                         output logic [3:0] nf);
        logic [W:0] s;
        logic c, v, cv_upd;
        c = mflags[1]; v = mflags[0]; cv_upd = 1'b1;
        rwe = 1'b1; fwe = 1'b1; s = '0;
        case (op)
            4'd0, 4'd6, 4'd1: begin
                s = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? {{W{1'b0}}, mflags[1]} : '0);
                c = s[W];
                v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
                if (op == 4'd6) rwe = 1'b0;
            end
            4'd2, 4'd5, 4'd3: begin
                s = {1'b0, a} - {1'b0, b} - ((op == 4'd3) ? {{W{1'b0}}, !mflags[1]} : '0);
                c = !s[W];
                v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
                if (op == 4'd5) rwe = 1'b0;
            end
            4'd4: begin
                s = {1'b0, {W{1'b0}}} - {1'b0, b};
                c = (b == '0);
                v = (b == {1'b1, {(W-1){1'b0}}});
            end
            4'd7: begin s[W-1:0] = a & b; rwe = 1'b0; cv_upd = 1'b0; end
            4'd8: begin s[W-1:0] = a * b; cv_upd = 1'b0; end
            default: begin rwe = 1'b0; fwe = 1'b0; cv_upd = 1'b0; end
        endcase
        r = s[W-1:0];
        if (fwe) nf = {r[W-1], (r == '0), cv_upd ? c : mflags[1], cv_upd ? v : mflags[0]};
        else     nf = mflags;
    endtask

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] er; logic erwe, efwe; logic [3:0] enf;
        string t;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        #1;
        model(op, a, b, er, erwe, efwe, enf);
        t = tag_of(op);
        if (erwe || op > 4'd8 || op == 4'd7) chk(t, result_o, er);
        chk("R7", {31'b0, res_we_o}, {31'b0, erwe});
        chk("R7", {31'b0, flag_we_o}, {31'b0, efwe});
        @(posedge clk); #1;
        mflags = enf;
        chk((op == 4'd7 || op == 4'd8 || op > 4'd8) ? t : "R6", {28'b0, flags_o}, {28'b0, mflags});
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R10", {28'b0, flags_o}, 32'h0);
        @(negedge clk); rst = 1'b0;
        mflags = 4'h0;

        apply(4'd0, 32'h8000_0000, 32'h8000_0000);   // R1: C,Z,V set
        chk("R1", {28'b0, flags_o}, 32'h7);
        apply(4'd1, 32'h0000_0001, 32'h0000_0001);   // R2: carry in set -> 3
        apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001);   // R5: N,V set, C clear
        chk("R5", {28'b0, flags_o}, 32'h9);
        apply(4'd1, 32'h0000_0005, 32'h0000_0002);   // R2: carry clear -> 7
        apply(4'd2, 32'h0000_0010, 32'h0000_0001);   // R3: no borrow
        chk("R3", {31'b0, flags_o[1]}, 32'h1);
        apply(4'd3, 32'h0000_0010, 32'h0000_0001);   // R3: C=1 -> 0xF
        apply(4'd2, 32'h0000_0001, 32'h0000_0002);   // R3: borrow
        apply(4'd3, 32'h0000_0010, 32'h0000_0001);   // R3: C=0 -> 0xE
        apply(4'd5, 32'h1234_5678, 32'h1234_5678);   // R7: compare equal, Z
        chk("R7", {31'b0, flags_o[2]}, 32'h1);
        apply(4'd4, 32'h0000_0000, 32'h0000_0000);   // R4: 0 - 0
        apply(4'd4, 32'h0000_0000, 32'h8000_0000);   // R4: most negative
        apply(4'd0, 32'h8000_0000, 32'h8000_0000);   // set C,V
        apply(4'd7, 32'hF000_0000, 32'h8000_0001);   // R8: N set, C,V kept
        chk("R8", {28'b0, flags_o}, 32'hB);
        apply(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R9: low word 1
        apply(4'd6, 32'hFFFF_FFFF, 32'h0000_0001);   // R1: compare-negative
        apply(4'd12, 32'h1, 32'h2);                  // R11: reserved
        apply(4'd8, 32'h0001_0000, 32'h0001_0000);   // R9: overflow lost, Z

        for (int i = 0; i < 400; i++) begin
            apply(4'($urandom % 16), pick(), pick());
        end

        // R10: reset mid-run with nonzero flags
        apply(4'd0, 32'h8000_0000, 32'h8000_0000);
        @(negedge clk); rst = 1'b1; op_i = 4'd15;
        @(posedge clk); #1;
        chk("R10", {28'b0, flags_o}, 32'h0);
        @(negedge clk); rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule